// File: doc/BRIEF.md
# Nine-Level Nearest-Level Gate Controller

This block drives the eleven power switches of a single-source, two-capacitor nine-level boost inverter. It produces one of nine output steps, from minus four to plus four times the DC input. A phase accumulator advances by a tuning word on every clock. Its phase reads a quarter-wave sine table, and the sample is scaled by a modulation index. Fixed thresholds, spaced one step apart, turn the scaled reference into a staircase level. That level selects a fixed eleven-bit gate pattern. It also selects the charge state of each flying capacitor.

The switches change only when the level changes, so each switch toggles at the fundamental rate and no carrier is used. An override input lets an external level code bypass the modulator. The mapping from level to gates can then be exercised directly. The gate word, the level code and the capacitor states are all registered, so they move on the same clock edge.

Top module: `nlc_gate_ctrl`

## Requirements
- R1: While `rst` is high, and on the clock edge after any cycle with `en` low, the outputs show the zero step: `gate` = 00110000101, `level` = 0, and both capacitor states idle.
- R2: `gate[10]` drives switch 1 and `gate[0]` drives switch 11. The patterns per level are: 0 → 00110000101, +1 → 01110000110, +2 → 10110110110, +3 → 01101010110, +4 → 10101010110, −1 → 01000111001, −2 → 10110111001, −3 → 01011101001, −4 → 10011101001.
- R3: Switch 11 (`gate[0]`) is on for level zero and every negative level. Switch 10 (`gate[1]`) is on for every positive level. The two are never on together.
- R4: Capacitor state codes are 00 idle, 01 charging and 10 discharging. Capacitor 1 charges at |level| 1 and 3, discharges at |level| 2 and 4, and is idle at 0. Capacitor 2 charges at |level| 2, discharges at |level| 3 and 4, and is idle at |level| 0 and 1.
- R5: `level` is a 4-bit two's-complement code of the output step. `gate`, `level` and both capacitor states update together on one clock edge.
- R6: With `en` and `ovr_en` high and `ovr_level` in −4..+4, the next edge shows `level` = `ovr_level` together with its R2 and R4 patterns.
- R7: An override code outside −4..+4 (−8..−5 or +5..+7) gives the zero step of R1.
- R8: With the override off, the reference is 4·M·sin θ, where M = `mod_index`/32768 and θ is the phase. |level| is the number of thresholds k − 0.5 (k = 1..4) that |reference| reaches. Over one period, the fraction of cycles with |level| ≥ k is therefore 1 − (2/π)·asin((k − 0.5)/(4M)), or zero when that argument is at least one.
- R9: The phase restarts at zero when `en` rises and advances by `tune_word` each clock, so the period is 2^32/`tune_word` cycles. Levels are non-negative during the first half of the phase turn and non-positive during the second half.
- R10: In modulator mode with `tune_word` ≤ 2^24 and steady inputs, `level` changes by at most one step per clock.
- R11: A modulation index below 1/8 keeps the level at zero for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the zero step and clears the phase |
| tune_word | input | 32 | Phase increment per clock |
| mod_index | input | 16 | Unsigned Q1.15 reference amplitude relative to four steps |
| ovr_en | input | 1 | Selects the override level instead of the modulator |
| ovr_level | input | 4 | Override level code, two's complement |
| gate | output | 11 | Switch commands, bit 10 = switch 1 |
| level | output | 4 | Current level code, two's complement |
| cap1_state | output | 2 | Capacitor 1 state code |
| cap2_state | output | 2 | Capacitor 2 state code |

## Verification
The bench drives every override code, including the seven codes outside the legal range. A decoder that wrapped those codes would emit a live boost pattern instead of the zero pattern. It then sweeps whole periods at full, partial, over-unity and tiny modulation indices, and compares the time spent at each |level| with the arcsine formula. A threshold placed at k instead of k − 0.5, or a wrong scaling, shifts those counts by hundreds of cycles. The sweep also checks that the polarity half-cycles are correct and that no level skips a step. A mirrored quarter-wave read with the wrong address or sign shows up as a negative level in the first half or as a two-step jump.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  localparam int NSW   = 11;
  localparam int NSTEP = 4;
  localparam int LVL_W = 4;
  localparam int CNT_W = $clog2(NSTEP + 1);

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic [NSW-1:0]          gate_t;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'b00,
    CAP_CHG  = 2'b01,
    CAP_DIS  = 2'b10
  } cap_t;

  localparam gate_t GATE_ZERO = 11'b00110000101;

  function automatic logic lvl_legal(lvl_t l);
    return (l >= -lvl_t'(NSTEP)) && (l <= lvl_t'(NSTEP));
  endfunction
endpackage

// File: rtl/nlc_sine_ref.sv
module nlc_sine_ref #(
  parameter int PH_W   = 32,
  parameter int TBL_AW = 6,
  parameter int MAG_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PH_W-1:0]  tune_word,
  output logic [MAG_W-1:0] mag,
  output logic             neg
);
  localparam int  DEPTH = 1 << TBL_AW;
  localparam real PI    = 3.14159265358979;
  localparam real AMP   = real'((1 << (MAG_W - 1)) - 1);

  logic [MAG_W-1:0]  rom [0:DEPTH-1];
  logic [PH_W-1:0]   phase;
  logic [TBL_AW-1:0] idx;
  logic [TBL_AW-1:0] addr;

  // quarter-wave table sampled at bin midpoints so mirroring is exact
  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = MAG_W'($rtoi(AMP * $sin((real'(i) + 0.5) * PI / (2.0 * DEPTH)) + 0.5));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) phase <= '0;
    else            phase <= phase + tune_word;
  end

  assign idx  = phase[PH_W-3 -: TBL_AW];
  assign addr = phase[PH_W-2] ? ~idx : idx;

  // table read without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    mag <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) neg <= 1'b0;
    else     neg <= phase[PH_W-1];
  end
endmodule

// File: rtl/nlc_level_quant.sv
module nlc_level_quant
  import nlc_pkg::*;
#(
  parameter int MAG_W = 16,
  parameter int MI_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MAG_W-1:0] mag,
  input  logic             neg,
  input  logic [MI_W-1:0]  mod_index,
  output lvl_t             lvl
);
  localparam int PRD_W = MAG_W + MI_W;
  localparam int STEP  = (1 << (MAG_W - 1)) / NSTEP;

  logic [PRD_W-1:0] prod;
  logic [PRD_W-1:0] scaled;
  logic [NSTEP-1:0] hit;
  logic [CNT_W-1:0] cnt;
  logic [LVL_W-1:0] mag_code;
  lvl_t             lvl_d;

  assign prod   = PRD_W'(mag) * PRD_W'(mod_index);
  assign scaled = prod >> (MI_W - 1);

  // one comparator per threshold, placed halfway between adjacent steps
  for (genvar k = 1; k <= NSTEP; k++) begin : g_thr
    localparam logic [PRD_W-1:0] TH = PRD_W'((2 * k - 1) * STEP / 2);
    assign hit[k-1] = (scaled >= TH);
  end

  assign cnt      = CNT_W'($countones(hit));
  assign mag_code = LVL_W'(cnt);

  always_comb begin
    if (neg) lvl_d = lvl_t'(LVL_W'(0) - mag_code);
    else     lvl_d = lvl_t'(mag_code);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) lvl <= '0;
    else            lvl <= lvl_d;
  end
endmodule

// File: rtl/nlc_gate_map.sv
module nlc_gate_map
  import nlc_pkg::*;
(
  input  lvl_t  lvl,
  output gate_t gate,
  output cap_t  cap1,
  output cap_t  cap2
);
  always_comb begin
    gate = GATE_ZERO;
    cap1 = CAP_IDLE;
    cap2 = CAP_IDLE;
    case (lvl)
      4'sd1:  begin gate = 11'b01110000110; cap1 = CAP_CHG; end
      4'sd2:  begin gate = 11'b10110110110; cap1 = CAP_DIS; cap2 = CAP_CHG; end
      4'sd3:  begin gate = 11'b01101010110; cap1 = CAP_CHG; cap2 = CAP_DIS; end
      4'sd4:  begin gate = 11'b10101010110; cap1 = CAP_DIS; cap2 = CAP_DIS; end
      -4'sd1: begin gate = 11'b01000111001; cap1 = CAP_CHG; end
      -4'sd2: begin gate = 11'b10110111001; cap1 = CAP_DIS; cap2 = CAP_CHG; end
      -4'sd3: begin gate = 11'b01011101001; cap1 = CAP_CHG; cap2 = CAP_DIS; end
      -4'sd4: begin gate = 11'b10011101001; cap1 = CAP_DIS; cap2 = CAP_DIS; end
      default: begin gate = GATE_ZERO; cap1 = CAP_IDLE; cap2 = CAP_IDLE; end
    endcase
  end
endmodule

// File: rtl/nlc_gate_ctrl.sv
module nlc_gate_ctrl
  import nlc_pkg::*;
#(
  parameter int PH_W   = 32,
  parameter int TBL_AW = 6,
  parameter int MAG_W  = 16,
  parameter int MI_W   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PH_W-1:0] tune_word,
  input  logic [MI_W-1:0] mod_index,
  input  logic            ovr_en,
  input  logic [3:0]      ovr_level,
  output logic [10:0]     gate,
  output logic [3:0]      level,
  output logic [1:0]      cap1_state,
  output logic [1:0]      cap2_state
);
  logic [MAG_W-1:0] ref_mag;
  logic             ref_neg;
  lvl_t             mod_lvl;
  lvl_t             sel_lvl;
  gate_t            map_gate;
  cap_t             map_c1;
  cap_t             map_c2;

  nlc_sine_ref #(.PH_W(PH_W), .TBL_AW(TBL_AW), .MAG_W(MAG_W)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tune_word (tune_word),
    .mag       (ref_mag),
    .neg       (ref_neg)
  );

  nlc_level_quant #(.MAG_W(MAG_W), .MI_W(MI_W)) u_quant (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mag       (ref_mag),
    .neg       (ref_neg),
    .mod_index (mod_index),
    .lvl       (mod_lvl)
  );

  always_comb begin
    sel_lvl = ovr_en ? lvl_t'(ovr_level) : mod_lvl;
    if (!lvl_legal(sel_lvl)) sel_lvl = '0;
  end

  nlc_gate_map u_map (
    .lvl  (sel_lvl),
    .gate (map_gate),
    .cap1 (map_c1),
    .cap2 (map_c2)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate       <= GATE_ZERO;
      level      <= '0;
      cap1_state <= CAP_IDLE;
      cap2_state <= CAP_IDLE;
    end else begin
      gate       <= map_gate;
      level      <= sel_lvl;
      cap1_state <= map_c1;
      cap2_state <= map_c2;
    end
  end
endmodule

// File: rtl/nlc_gate_ctrl_chk.sv
module nlc_gate_ctrl_chk
  import nlc_pkg::*;
#(
  parameter int PH_W   = 32,
  parameter int TBL_AW = 6,
  parameter int MI_W   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [PH_W-1:0] tune_word,
  input logic [MI_W-1:0] mod_index,
  input logic            ovr_en,
  input logic [3:0]      ovr_level,
  input logic [10:0]     gate,
  input logic [3:0]      level,
  input logic [1:0]      cap1_state,
  input logic [1:0]      cap2_state
);
  localparam logic [PH_W-1:0] SLOW_LIM = PH_W'(1) << (PH_W - 2 - TBL_AW);

  logic [2:0]      run;
  logic [PH_W-1:0] tw_q;
  logic [MI_W-1:0] mi_q;
  logic            ovr_ok;
  int              lv;

  assign ovr_ok = ($signed(ovr_level) >= -4) && ($signed(ovr_level) <= 4);
  assign lv     = int'($signed(level));

  // cycles of steady modulator operation, saturating
  always_ff @(posedge clk) begin
    tw_q <= tune_word;
    mi_q <= mod_index;
    if (rst || !en || ovr_en || tune_word > SLOW_LIM ||
        tune_word != tw_q || mod_index != mi_q)
      run <= '0;
    else if (run != 3'd7)
      run <= run + 3'd1;
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level == 4'd0 && gate == GATE_ZERO && cap1_state == 2'b00 && cap2_state == 2'b00));

  a_r2_zero_word: assert property (@(posedge clk) disable iff (rst)
    (level == 4'd0) |-> (gate == GATE_ZERO));

  a_r3_pos_polarity: assert property (@(posedge clk) disable iff (rst)
    (lv > 0) |-> (gate[1] && !gate[0]));

  a_r3_nonpos_polarity: assert property (@(posedge clk) disable iff (rst)
    (lv <= 0) |-> (gate[0] && !gate[1]));

  a_r4_cap2_idle: assert property (@(posedge clk) disable iff (rst)
    (lv >= -1 && lv <= 1) |-> (cap2_state == 2'b00));

  a_r4_cap1_active: assert property (@(posedge clk) disable iff (rst)
    (lv != 0) |-> (cap1_state != 2'b00));

  a_r6_override: assert property (@(posedge clk) disable iff (rst)
    (en && ovr_en && ovr_ok) |=> (level == $past(ovr_level)));

  a_r7_bad_code: assert property (@(posedge clk) disable iff (rst)
    (en && ovr_en && !ovr_ok) |=> (level == 4'd0 && gate == GATE_ZERO));

  a_r10_one_step: assert property (@(posedge clk) disable iff (rst)
    (run >= 3'd5) |-> ((lv - int'($signed($past(level)))) <= 1 &&
                       (lv - int'($signed($past(level)))) >= -1));
endmodule

bind nlc_gate_ctrl nlc_gate_ctrl_chk #(.PH_W(PH_W), .TBL_AW(TBL_AW), .MI_W(MI_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .tune_word  (tune_word),
  .mod_index  (mod_index),
  .ovr_en     (ovr_en),
  .ovr_level  (ovr_level),
  .gate       (gate),
  .level      (level),
  .cap1_state (cap1_state),
  .cap2_state (cap2_state)
);

// File: tb/tb_nlc_gate_ctrl.sv
module tb_nlc_gate_ctrl;
  localparam int  PERIOD = 4096;
  localparam real PI     = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] tune_word = '0;
  logic [15:0] mod_index = '0;
  logic        ovr_en = 1'b0;
  logic [3:0]  ovr_level = '0;
  logic [10:0] gate;
  logic [3:0]  level;
  logic [1:0]  cap1_state;
  logic [1:0]  cap2_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nlc_gate_ctrl dut (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word), .mod_index(mod_index),
    .ovr_en(ovr_en), .ovr_level(ovr_level), .gate(gate), .level(level),
    .cap1_state(cap1_state), .cap2_state(cap2_state)
  );

  function automatic logic [10:0] exp_gate(int l);
    case (l)
      1:  return 11'b01110000110;
      2:  return 11'b10110110110;
      3:  return 11'b01101010110;
      4:  return 11'b10101010110;
      -1: return 11'b01000111001;
      -2: return 11'b10110111001;
      -3: return 11'b01011101001;
      -4: return 11'b10011101001;
      default: return 11'b00110000101;
    endcase
  endfunction

  function automatic logic [1:0] exp_c1(int l);
    int a = (l < 0) ? -l : l;
    if (a == 0) return 2'b00;
    return (a % 2 == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] exp_c2(int l);
    int a = (l < 0) ? -l : l;
    if (a <= 1) return 2'b00;
    return (a == 2) ? 2'b01 : 2'b10;
  endfunction

  function automatic int exp_at_least(int k, real m);
    real x = (real'(k) - 0.5) / (4.0 * m);
    if (x >= 1.0) return 0;
    return $rtoi(real'(PERIOD) * (1.0 - 2.0 * $asin(x) / PI));
  endfunction

  function automatic int code_of(logic [3:0] c);
    return int'($signed(c));
  endfunction

  task automatic check_out(int l, string req);
    checks++;
    if (code_of(level) != l || gate != exp_gate(l) ||
        cap1_state != exp_c1(l) || cap2_state != exp_c2(l)) begin
      errors++;
      $display("FAIL %s: level=%0d gate=%b c1=%b c2=%b expected level=%0d gate=%b c1=%b c2=%b",
               req, code_of(level), gate, cap1_state, cap2_state,
               l, exp_gate(l), exp_c1(l), exp_c2(l));
    end
  endtask

  task automatic check_int(int act, int expv, int tol, string req);
    int d = act - expv;
    checks++;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (tol %0d)", req, act, expv, tol);
    end
  endtask

  // one full modulator period from a fresh enable
  task automatic sweep(logic [15:0] mi, string tag);
    int ge[1:4];
    int bad_word = 0, bad_pol = 0, bad_step = 0;
    int prev = 0;
    real m = real'(mi) / 32768.0;
    for (int k = 1; k <= 4; k++) ge[k] = 0;
    @(negedge clk);
    en = 1'b0; ovr_en = 1'b0; mod_index = mi; tune_word = 32'h0010_0000;
    repeat (4) @(negedge clk);
    check_out(0, "R1 disabled before sweep");
    en = 1'b1;
    for (int n = 1; n <= PERIOD + 8; n++) begin
      @(negedge clk);
      begin
        int l = code_of(level);
        int a = (l < 0) ? -l : l;
        if (gate != exp_gate(l) || cap1_state != exp_c1(l) || cap2_state != exp_c2(l)) bad_word++;
        if (n >= 8 && n <= 2040 && l < 0) bad_pol++;
        if (n >= 2060 && n <= 4090 && l > 0) bad_pol++;
        if (n > 1 && (l - prev > 1 || prev - l > 1)) bad_step++;
        prev = l;
        if (n >= 8 && n < 8 + PERIOD)
          for (int k = 1; k <= 4; k++) if (a >= k) ge[k]++;
      end
    end
    check_int(bad_word, 0, 0, {"R2 R4 modulator words ", tag});
    check_int(bad_pol, 0, 0, {"R9 half-cycle polarity ", tag});
    check_int(bad_step, 0, 0, {"R10 single-step moves ", tag});
    for (int k = 1; k <= 4; k++)
      check_int(ge[k], exp_at_least(k, m), 100, {"R8 time at |level|>=k ", tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check_out(0, "R1 reset state");
    en = 1'b1; ovr_en = 1'b1; ovr_level = 4'd3;
    @(negedge clk);
    check_out(0, "R1 held in reset");
    rst = 1'b0;
    @(negedge clk);
    check_out(3, "R6 first override after reset");

    // every override code, legal and out of range (R5 R6 R7)
    for (int c = -8; c <= 7; c++) begin
      ovr_level = 4'(c);
      @(negedge clk);
      check_out((c >= -4 && c <= 4) ? c : 0, (c >= -4 && c <= 4) ? "R6 R2 R4 override" : "R7 illegal code");
    end

    // disable drops to zero at the next edge
    ovr_level = 4'sd4;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_out(0, "R1 enable low");

    // random override traffic
    for (int i = 0; i < 80; i++) begin
      int c = int'($signed(4'($urandom)));
      bit e = ($urandom % 8) != 0;
      en = e; ovr_en = 1'b1; ovr_level = 4'(c);
      @(negedge clk);
      check_out(!e ? 0 : ((c >= -4 && c <= 4) ? c : 0), "R3 R5 R6 R7 random override");
    end

    sweep(16'h8000, "M=1.0");
    sweep(16'h4CCD, "M=0.6");
    sweep(16'hC000, "M=1.5");
    sweep(16'h0CCD, "R11 M=0.1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule